// File: doc/BRIEF.md
# Coprocessor Interrupt Pending and Mask Unit

This unit gathers eight level-sensitive interrupt lines for a system coprocessor. It records them in a pending field and filters that field through a writable mask field and one global enable bit. From the result it produces a single hard-interrupt request to the CPU core. Each line comes from the OR of a direct core input and, for lines 2 and above, an input from an external peripheral interrupt controller. External input i feeds line i+2. External inputs that would land beyond line 7 have no effect.

Software sets the mask and the global enable through a small write port. The pending field, the mask field and the enable bit can all be read back. For statistics, each line has a saturating counter. It counts the times that line newly raised an interrupt to the core while it was allowed to. A select input picks which counter appears on a read data output.

Top module: `cp0_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the pending field, the mask field, the global enable and every counter become zero, and `hard_irq_o` is low.
- R2: Pending bit n (`pend_o[n]`) takes the level of line n at each rising edge. It is set when the line is high and cleared when it is low, whatever the mask and enable are.
- R3: When `st_we` is high at a rising edge, `mask_o` takes `st_wr_mask` and `gie_o` takes `st_wr_gie`. When `st_we` is low, both keep their values.
- R4: `hard_irq_o` is high exactly when `gie_o` is 1 and some bit n has both `pend_o[n]` and `mask_o[n]` set. A status write alone can raise or drop it in the cycle after the write edge.
- R5: `ext_irq[i]` drives line i+2, ORed with `core_irq[i+2]`. For example, `ext_irq[0]` sets `pend_o[2]`.
- R6: `ext_irq[6]` and `ext_irq[7]` map past line 7. They change no pending bit, no counter and no request.
- R7: Counter n goes up by one at the edge where line n is high while `pend_o[n]` is 0, `gie_o` is 1 and `mask_o[n]` is 1. A line held high, a masked line or a disabled unit adds nothing.
- R8: A counter at all ones stays at all ones.
- R9: `cnt_rdata` shows counter number `cnt_sel` (0 to 7) combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_irq | input | 8 | Direct level interrupt lines 0 to 7 |
| ext_irq | input | EXT_W (8) | External controller inputs; input i drives line i+2 |
| st_we | input | 1 | Status write strobe |
| st_wr_mask | input | 8 | Mask field value to write |
| st_wr_gie | input | 1 | Global enable value to write |
| pend_o | output | 8 | Pending field |
| mask_o | output | 8 | Mask field |
| gie_o | output | 1 | Global enable |
| hard_irq_o | output | 1 | Hard-interrupt request to the core |
| cnt_sel | input | 3 | Counter select |
| cnt_rdata | output | CNT_W (32) | Selected counter value |

## Verification
The pending bits and the counters change at the first rising edge after a line changes. Mask and enable change at the first edge after a write. The request follows the registers with no extra delay, and the counter read path has no register at all. Each directed task therefore drives its inputs 1 ns after an edge and lets exactly one edge pass. It then samples 1 ns later, and walks `cnt_sel` through the eight counters in short steps that finish well before the next edge. The bench builds the unit with 4-bit counters so that saturation can be reached in a few dozen cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_LINES = 8;
  localparam int EXT_BASE  = 2;
  localparam int SEL_W     = $clog2(IRQ_LINES);

  typedef logic [IRQ_LINES-1:0] line_vec_t;

  // Lines that newly raise a request toward the core this cycle
  function automatic line_vec_t raise_events(line_vec_t lvl, line_vec_t pend,
                                             line_vec_t mask, logic gie);
    return lvl & ~pend & mask & {IRQ_LINES{gie}};
  endfunction

  // Request to the core from the registered state
  function automatic logic request_of(line_vec_t pend, line_vec_t mask, logic gie);
    return gie & (|(pend & mask));
  endfunction
endpackage

// File: rtl/irqc_line_map.sv
module irqc_line_map
  import irqc_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  line_vec_t        core_irq,
  input  logic [EXT_W-1:0] ext_irq,
  output line_vec_t        line_lvl,
  output logic [EXT_W-1:0] ext_drop
);
  for (genvar n = 0; n < IRQ_LINES; n++) begin : g_line
    if (n >= EXT_BASE && (n - EXT_BASE) < EXT_W) begin : g_shared
      assign line_lvl[n] = core_irq[n] | ext_irq[n-EXT_BASE];
    end else begin : g_direct
      assign line_lvl[n] = core_irq[n];
    end
  end

  for (genvar i = 0; i < EXT_W; i++) begin : g_drop
    if (i + EXT_BASE >= IRQ_LINES) begin : g_out
      assign ext_drop[i] = ext_irq[i];
    end else begin : g_in
      assign ext_drop[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  line_vec_t wr_mask,
  input  logic      wr_gie,
  output line_vec_t mask,
  output logic      gie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      gie  <= 1'b0;
    end else if (we) begin
      mask <= wr_mask;
      gie  <= wr_gie;
    end
  end
endmodule

// File: rtl/irqc_evt_cnt.sv
module irqc_evt_cnt
  import irqc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  line_vec_t        evt,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt [IRQ_LINES];

  for (genvar n = 0; n < IRQ_LINES; n++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[n] <= '0;
      else if (evt[n]) cnt[n] <= sat_inc(cnt[n]);
    end
  end

  assign rdata = cnt[sel];
endmodule

// File: rtl/cp0_irq_ctrl.sv
module cp0_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int EXT_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       core_irq,
  input  logic [EXT_W-1:0] ext_irq,
  input  logic             st_we,
  input  logic [7:0]       st_wr_mask,
  input  logic             st_wr_gie,
  output logic [7:0]       pend_o,
  output logic [7:0]       mask_o,
  output logic             gie_o,
  output logic             hard_irq_o,
  input  logic [2:0]       cnt_sel,
  output logic [CNT_W-1:0] cnt_rdata
);
  line_vec_t        line_lvl;
  logic [EXT_W-1:0] ext_drop;
  line_vec_t        pend_q;
  line_vec_t        mask_q;
  logic             gie_q;
  line_vec_t        raise_evt;

  irqc_line_map #(.EXT_W(EXT_W)) u_map (
    .core_irq (core_irq),
    .ext_irq  (ext_irq),
    .line_lvl (line_lvl),
    .ext_drop (ext_drop)
  );

  irqc_status_reg u_status (
    .clk     (clk),
    .rst     (rst),
    .we      (st_we),
    .wr_mask (st_wr_mask),
    .wr_gie  (st_wr_gie),
    .mask    (mask_q),
    .gie     (gie_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= line_lvl;
  end

  assign raise_evt = raise_events(line_lvl, pend_q, mask_q, gie_q);

  irqc_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .evt   (raise_evt),
    .sel   (cnt_sel),
    .rdata (cnt_rdata)
  );

  assign pend_o     = pend_q;
  assign mask_o     = mask_q;
  assign gie_o      = gie_q;
  assign hard_irq_o = request_of(pend_q, mask_q, gie_q);
endmodule

// File: rtl/cp0_irq_ctrl_chk.sv
module cp0_irq_ctrl_chk #(
  parameter int EXT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       core_irq,
  input logic [EXT_W-1:0] ext_irq,
  input logic             st_we,
  input logic [7:0]       st_wr_mask,
  input logic             st_wr_gie,
  input logic [7:0]       pend_o,
  input logic [7:0]       mask_o,
  input logic             gie_o,
  input logic             hard_irq_o,
  input logic [7:0]       line_lvl,
  input logic [EXT_W-1:0] ext_drop,
  input logic [7:0]       raise_evt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_o == 8'h00 && mask_o == 8'h00 && !gie_o && !hard_irq_o));

  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pend_o == $past(line_lvl));

  // R3
  status_write_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |=> (mask_o == $past(st_wr_mask) && gie_o == $past(st_wr_gie)));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_we |=> ($stable(mask_o) && $stable(gie_o)));

  // R4
  req_gated_chk: assert property (@(posedge clk) disable iff (rst)
    hard_irq_o |-> (gie_o && (pend_o & mask_o) != 8'h00));

  // R4
  req_present_chk: assert property (@(posedge clk) disable iff (rst)
    (gie_o && (pend_o & mask_o) != 8'h00) |-> hard_irq_o);

  // R6
  ext_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_drop != '0 && core_irq == 8'h00 && (ext_irq & ~ext_drop) == '0)
      |=> pend_o == 8'h00);

  // R7
  raise_allowed_chk: assert property (@(posedge clk) disable iff (rst)
    raise_evt != 8'h00 |-> (gie_o && (raise_evt & ~mask_o) == 8'h00
                            && (raise_evt & pend_o) == 8'h00));

  // R7
  raise_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    raise_evt != 8'h00 |=> (pend_o & $past(raise_evt)) == $past(raise_evt));
endmodule

bind cp0_irq_ctrl cp0_irq_ctrl_chk #(.EXT_W(EXT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_irq   (core_irq),
  .ext_irq    (ext_irq),
  .st_we      (st_we),
  .st_wr_mask (st_wr_mask),
  .st_wr_gie  (st_wr_gie),
  .pend_o     (pend_o),
  .mask_o     (mask_o),
  .gie_o      (gie_o),
  .hard_irq_o (hard_irq_o),
  .line_lvl   (line_lvl),
  .ext_drop   (ext_drop),
  .raise_evt  (raise_evt)
);

// File: tb/cp0_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cp0_irq_ctrl_bench;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    core_irq = '0;
  logic [7:0]    ext_irq = '0;
  logic          st_we = 1'b0;
  logic [7:0]    st_wr_mask = '0;
  logic          st_wr_gie = 1'b0;
  logic [7:0]    pend_o, mask_o;
  logic          gie_o, hard_irq_o;
  logic [2:0]    cnt_sel = '0;
  logic [CW-1:0] cnt_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]    m_pend, m_mask;
  logic          m_gie;
  logic [CW-1:0] m_cnt [8];

  always #2.5 clk = ~clk;

  cp0_irq_ctrl #(.EXT_W(8), .CNT_W(CW)) u_cp0_irq_ctrl (
    .clk(clk), .rst(rst), .core_irq(core_irq), .ext_irq(ext_irq),
    .st_we(st_we), .st_wr_mask(st_wr_mask), .st_wr_gie(st_wr_gie),
    .pend_o(pend_o), .mask_o(mask_o), .gie_o(gie_o), .hard_irq_o(hard_irq_o),
    .cnt_sel(cnt_sel), .cnt_rdata(cnt_rdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Line levels as the requirements define them: ext i lands on line i+2
  function automatic logic [7:0] want_lines();
    logic [7:0] l = core_irq;
    for (int i = 0; i < 6; i++) l[i+2] = l[i+2] | ext_irq[i];
    return l;
  endfunction

  task automatic step();
    logic [7:0] l = want_lines();
    logic [7:0] ev = l & ~m_pend & (m_gie ? m_mask : 8'h00);
    for (int n = 0; n < 8; n++)
      if (ev[n] && m_cnt[n] != CMAX) m_cnt[n] = m_cnt[n] + 1'b1;
    m_pend = l;
    if (st_we) begin
      m_mask = st_wr_mask;
      m_gie  = st_wr_gie;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic wr_status(logic [7:0] msk, logic g);
    st_we = 1'b1; st_wr_mask = msk; st_wr_gie = g;
    step();
    st_we = 1'b0;
  endtask

  task automatic check_all(string req);
    chk(req, "pend", pend_o, m_pend);
    chk(req, "mask", mask_o, m_mask);
    chk(req, "gie", gie_o, m_gie);
    chk(req, "hard_irq", hard_irq_o, m_gie && ((m_pend & m_mask) != 0));
    for (int n = 0; n < 8; n++) begin
      cnt_sel = n[2:0];
      #0.2;
      chk(req, $sformatf("cnt%0d", n), cnt_rdata, m_cnt[n]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    m_pend = '0; m_mask = '0; m_gie = 1'b0;
    for (int n = 0; n < 8; n++) m_cnt[n] = '0;
    check_all("R1");
    check_all("R9");
  endtask

  task automatic t_pending();
    core_irq = 8'hA5; step();
    chk("R2", "pend set", pend_o, 8'hA5);
    chk("R4", "no req while disabled", hard_irq_o, 1'b0);
    core_irq = 8'h21; step();
    chk("R2", "pend partial clear", pend_o, 8'h21);
    core_irq = 8'h00; step();
    chk("R2", "pend cleared", pend_o, 8'h00);
    check_all("R2");
  endtask

  task automatic t_status();
    wr_status(8'h5A, 1'b1);
    chk("R3", "mask write", mask_o, 8'h5A);
    chk("R3", "gie write", gie_o, 1'b1);
    st_wr_mask = 8'hFF; st_wr_gie = 1'b0; step();
    chk("R3", "mask hold without strobe", mask_o, 8'h5A);
    chk("R3", "gie hold without strobe", gie_o, 1'b1);
    wr_status(8'h00, 1'b0);
    check_all("R3");
  endtask

  task automatic t_request();
    wr_status(8'h10, 1'b1);
    core_irq = 8'h10; step();
    chk("R4", "req on masked-in line", hard_irq_o, 1'b1);
    wr_status(8'h10, 1'b0);
    chk("R4", "req dropped by gie", hard_irq_o, 1'b0);
    wr_status(8'hEF, 1'b1);
    chk("R4", "req off when mask bit clear", hard_irq_o, 1'b0);
    wr_status(8'h10, 1'b1);
    chk("R4", "req raised by status write", hard_irq_o, 1'b1);
    core_irq = 8'h00; step();
    chk("R4", "req follows pend low", hard_irq_o, 1'b0);
    check_all("R4");
  endtask

  task automatic t_ext();
    wr_status(8'hFF, 1'b1);
    ext_irq = 8'h01; step();
    chk("R5", "ext0 to line2", pend_o, 8'h04);
    ext_irq = 8'h20; step();
    chk("R5", "ext5 to line7", pend_o, 8'h80);
    ext_irq = 8'h00; step();
    ext_irq = 8'hC0; step();
    chk("R6", "ext6/7 no pend", pend_o, 8'h00);
    chk("R6", "ext6/7 no req", hard_irq_o, 1'b0);
    ext_irq = 8'h00; step();
    check_all("R6");
  endtask

  task automatic t_count();
    wr_status(8'hDF, 1'b1);
    for (int k = 0; k < 2; k++) begin
      core_irq = 8'h08; step();
      core_irq = 8'h00; step();
    end
    core_irq = 8'h08; step(); step(); step();
    core_irq = 8'h20; step();
    core_irq = 8'h00; step();
    wr_status(8'hFF, 1'b0);
    core_irq = 8'h02; step();
    core_irq = 8'h00; step();
    check_all("R7");
    cnt_sel = 3'd3; #0.2;
    chk("R7", "line3 raise count", cnt_rdata, 3);
    cnt_sel = 3'd5; #0.2;
    chk("R7", "masked line5 count", cnt_rdata, 0);
    cnt_sel = 3'd1; #0.2;
    chk("R9", "disabled line1 count", cnt_rdata, 0);
  endtask

  task automatic t_sat();
    wr_status(8'h01, 1'b1);
    for (int k = 0; k < 20; k++) begin
      core_irq = 8'h01; step();
      core_irq = 8'h00; step();
    end
    cnt_sel = 3'd0; #0.2;
    chk("R8", "saturated count", cnt_rdata, CMAX);
    check_all("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pending();
    t_status();
    t_request();
    t_ext();
    t_count();
    t_sat();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule